// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier with High/Low Result Registers

This block multiplies two 32-bit operands over many clock cycles using a single 32-bit adder and one 64-bit product register that shifts right. A one-cycle start pulse launches an operation. A select input chooses between an unsigned multiply and a two's-complement signed multiply. The 64-bit result is split across two result registers. The upper word can be read on one output port and the lower word on another. These registers change only when an operation finishes.

When the operation starts, the multiplier operand is placed in the lower half of the product register and the upper half is cleared. On each step, bit 0 of the product register decides whether the multiplicand is added into the upper half. The adder's carry and the sum are then shifted right together with the rest of the register, so no carry bit is lost. A signed operation first turns both operands into magnitudes and records whether the operand signs differ. If they differ, the finished 64-bit product is negated in one extra cycle before completion is signalled.

Top module: `seq_mul_hilo`

## Requirements
- R1: While reset is held and after it is released, `hi_o` and `lo_o` read zero and both `busy_o` and `done_o` are low.
- R2: With `is_signed_i` low, the operands are treated as unsigned. The completed result {`hi_o`,`lo_o`} equals the full 64-bit unsigned product, with `hi_o` holding bits 63:32 and `lo_o` holding bits 31:0.
- R3: With `is_signed_i` high, the operands are treated as two's-complement numbers. {`hi_o`,`lo_o`} equals the 64-bit two's-complement product.
- R4: A `start_i` sampled high while idle is accepted. `busy_o` is high from the next cycle onward. The operands and the select are captured at that edge.
- R5: `done_o` is high for exactly one cycle. It goes high 32 clock edges after the accepting edge when no negation is needed. It goes high 33 edges after the accepting edge for a signed operation whose operand sign bits differ. `busy_o` falls at the same edge that raises `done_o`.
- R6: A `start_i` pulse while `busy_o` is high is ignored. Operand or select changes after the accepting edge are also ignored. The running result, its latency and the number of `done_o` pulses are unchanged.
- R7: `hi_o` and `lo_o` keep their previous values during an operation and change only at the edge that raises `done_o`.
- R8: The boundary operands give exact results. Unsigned 0xFFFFFFFF squared gives 0xFFFFFFFE_00000001, which needs the adder carry. Signed 0x80000000 squared gives 0x40000000_00000000. Signed 0x80000000 times 1 gives 0xFFFFFFFF_80000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled while idle |
| is_signed_i | input | 1 | 1 = two's-complement multiply, 0 = unsigned multiply |
| op_a_i | input | 32 | Multiplicand operand |
| op_b_i | input | 32 | Multiplier operand |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | 32 | Upper word of the last completed product |
| lo_o | output | 32 | Lower word of the last completed product |

## Verification
Every result is due at a fixed edge count after the edge that accepts `start_i`:
- `busy_o` is due after one edge.
- `done_o` and the new `hi_o`/`lo_o` are due after 32 edges, or after 33 edges when the signed operand signs differ.

The bench drives inputs and samples outputs on falling edges. After the start pulse it counts falling edges until `done_o` appears. It compares that count with the expected 32 or 33, and compares the result words in that same cycle. For the ignored-start case, the bench keeps counting through the whole window and checks that no second completion pulse appears. It also checks that the result words held their old values during the run.

// File: rtl/mulseq_pkg.sv
package mulseq_pkg;

    // Default operand width of the multiplier
    localparam int unsigned DATA_W = 32;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } mul_state_e;

    // Per-operation mode captured at start
    typedef struct packed {
        logic is_signed;
        logic flip_sign;
    } mul_mode_t;

    // Sign decision: result negative only for signed ops with differing signs
    function automatic logic want_flip(input logic is_signed, input logic sa, input logic sb);
        return is_signed & (sa ^ sb);
    endfunction

endpackage

// File: rtl/mul_operand_prep.sv
module mul_operand_prep
    import mulseq_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W
) (
    input  logic             is_signed_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] a_mag_o,
    output logic [WIDTH-1:0] b_mag_o,
    output mul_mode_t        mode_o
);

    localparam int unsigned MSB = WIDTH - 1;

    logic a_neg;
    logic b_neg;

    assign a_neg = is_signed_i & a_i[MSB];
    assign b_neg = is_signed_i & b_i[MSB];

    // Magnitudes: the most negative value maps to 2^(WIDTH-1) as unsigned
    assign a_mag_o = a_neg ? (~a_i + WIDTH'(1)) : a_i;
    assign b_mag_o = b_neg ? (~b_i + WIDTH'(1)) : b_i;

    assign mode_o.is_signed = is_signed_i;
    assign mode_o.flip_sign = want_flip(is_signed_i, a_i[MSB], b_i[MSB]);

endmodule

// File: rtl/mul_step.sv
module mul_step
    import mulseq_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W
) (
    input  logic [2*WIDTH-1:0] prod_i,
    input  logic [WIDTH-1:0]   mcand_i,
    output logic [2*WIDTH-1:0] prod_o
);

    localparam int unsigned PW = 2 * WIDTH;

    logic [WIDTH-1:0] addend;
    logic [WIDTH:0]   sum;

    // Add the multiplicand into the upper half only when the tested bit is set
    assign addend = prod_i[0] ? mcand_i : '0;
    assign sum    = {1'b0, prod_i[PW-1:WIDTH]} + {1'b0, addend};

    // Carry enters the top bit while everything moves right by one
    assign prod_o = {sum, prod_i[WIDTH-1:1]};

endmodule

// File: rtl/seq_mul_hilo.sv
module seq_mul_hilo
    import mulseq_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             is_signed_i,
    input  logic [WIDTH-1:0] op_a_i,
    input  logic [WIDTH-1:0] op_b_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o
);

    localparam int unsigned PW   = 2 * WIDTH;
    localparam int unsigned CW   = $clog2(WIDTH);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    mul_state_e       state_q;
    logic [CW-1:0]    cnt_q;
    logic [WIDTH-1:0] mcand_q;
    logic [PW-1:0]    prod_q;
    mul_mode_t        mode_q;
    logic [WIDTH-1:0] hi_q;
    logic [WIDTH-1:0] lo_q;
    logic             done_q;

    logic [WIDTH-1:0] a_mag;
    logic [WIDTH-1:0] b_mag;
    mul_mode_t        mode_d;
    logic [PW-1:0]    prod_next;
    logic [PW-1:0]    prod_neg;

    mul_operand_prep #(.WIDTH(WIDTH)) u_prep (
        .is_signed_i (is_signed_i),
        .a_i         (op_a_i),
        .b_i         (op_b_i),
        .a_mag_o     (a_mag),
        .b_mag_o     (b_mag),
        .mode_o      (mode_d)
    );

    mul_step #(.WIDTH(WIDTH)) u_step (
        .prod_i  (prod_q),
        .mcand_i (mcand_q),
        .prod_o  (prod_next)
    );

    assign prod_neg = ~prod_q + PW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            mcand_q <= '0;
            prod_q  <= '0;
            mode_q  <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        mcand_q <= a_mag;
                        prod_q  <= {{WIDTH{1'b0}}, b_mag};
                        mode_q  <= mode_d;
                        cnt_q   <= '0;
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    prod_q <= prod_next;
                    cnt_q  <= cnt_q + CW'(1);
                    if (cnt_q == LAST) begin
                        if (mode_q.flip_sign) begin
                            state_q <= ST_FIX;
                        end else begin
                            hi_q    <= prod_next[PW-1:WIDTH];
                            lo_q    <= prod_next[WIDTH-1:0];
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_FIX: begin
                    hi_q    <= prod_neg[PW-1:WIDTH];
                    lo_q    <= prod_neg[WIDTH-1:0];
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = (state_q != ST_IDLE);
    assign done_o = done_q;
    assign hi_o   = hi_q;
    assign lo_o   = lo_q;

    AST_START_ACCEPTED: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> busy_o); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R5

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o); // R5

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (start_i && state_q == ST_RUN && cnt_q != LAST) |=> (busy_o && $stable(mcand_q))); // R6

    AST_HILO_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(hi_o) && $stable(lo_o))); // R7

endmodule

// File: tb/seq_mul_hilo_tb.sv
`timescale 1ns/1ps
module seq_mul_hilo_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        is_signed_i = 1'b0;
    logic [31:0] op_a_i = '0;
    logic [31:0] op_b_i = '0;
    logic        busy_o;
    logic        done_o;
    logic [31:0] hi_o;
    logic [31:0] lo_o;

    int n_checks = 0;
    int n_fail   = 0;
    int wd_cnt   = 0;

    always #2.5 clk = ~clk;

    seq_mul_hilo u_dut (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .is_signed_i (is_signed_i),
        .op_a_i      (op_a_i),
        .op_b_i      (op_b_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .hi_o        (hi_o),
        .lo_o        (lo_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%016h expected=0x%016h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_mul(input logic [31:0] a, input logic [31:0] b, input logic s);
        logic signed [63:0] sa;
        logic signed [63:0] sb;
        if (s) begin
            sa = {{32{a[31]}}, a};
            sb = {{32{b[31]}}, b};
            return sa * sb;
        end
        return {32'b0, a} * {32'b0, b};
    endfunction

    // Accepting edge is the one right after start is raised; done due 32 or 33 edges later
    task automatic run_mul(input string req, input logic [31:0] a, input logic [31:0] b, input logic s);
        int cyc;
        int exp_lat;
        exp_lat = (s && (a[31] ^ b[31])) ? 33 : 32;
        @(negedge clk);
        op_a_i = a; op_b_i = b; is_signed_i = s; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        op_a_i = ~a; op_b_i = b ^ 32'h5A5A_A5A5; is_signed_i = ~s;   // R6: late changes ignored
        check("R4 busy after accept", {63'b0, busy_o}, 64'd1);
        cyc = 0;
        while (!done_o && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        check({req, " latency R5"}, 64'(cyc), 64'(exp_lat));
        check({req, " result"}, {hi_o, lo_o}, ref_mul(a, b, s));
        check("R5 busy low at done", {63'b0, busy_o}, 64'd0);
        @(negedge clk);
        check("R5 done one cycle", {63'b0, done_o}, 64'd0);
    endtask

    task automatic test_reset();
        check("R1 hi/lo at reset", {hi_o, lo_o}, 64'd0);
        check("R1 busy at reset", {63'b0, busy_o}, 64'd0);
        check("R1 done at reset", {63'b0, done_o}, 64'd0);
    endtask

    // R6/R7: restart attempt mid-run and hold of old result
    task automatic test_busy_start();
        int cyc;
        int dones;
        logic [63:0] prev;
        prev = {hi_o, lo_o};
        @(negedge clk);
        op_a_i = 32'd1234; op_b_i = 32'd5678; is_signed_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        dones = 0;
        while (!done_o && cyc < 100) begin
            @(negedge clk);
            cyc++;
            if (cyc == 5) begin
                op_a_i = 32'hFFFF_FFF0; op_b_i = 32'h8000_0001; is_signed_i = 1'b1; start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            if (cyc == 20) check("R7 hi/lo held mid-run", {hi_o, lo_o}, prev);
        end
        check("R6 latency with ignored start", 64'(cyc), 64'd32);
        check("R6 result of first op", {hi_o, lo_o}, 64'd1234 * 64'd5678);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (done_o) dones++;
        end
        check("R6 no second done", 64'(dones), 64'd0);
        check("R7 hi/lo hold after done", {hi_o, lo_o}, 64'd1234 * 64'd5678);
    endtask

    always @(posedge clk) begin
        wd_cnt++;
        if (wd_cnt > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000 cycles", wd_cnt);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        run_mul("R2 small unsigned", 32'd7, 32'd9, 1'b0);
        run_mul("R2 wide unsigned", 32'hDEAD_BEEF, 32'h1234_5678, 1'b0);
        run_mul("R2 zero operand", 32'h0, 32'hFFFF_FFFF, 1'b0);
        run_mul("R8 all ones unsigned", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        run_mul("R3 pos x pos", 32'd300, 32'd70000, 1'b1);
        run_mul("R3 neg x pos", 32'hFFFF_FFFD, 32'd5, 1'b1);
        run_mul("R3 pos x neg", 32'd12345, 32'hFFFF_0000, 1'b1);
        run_mul("R3 neg x neg", 32'hFFFF_FFFF, 32'hFFFF_FFFE, 1'b1);
        run_mul("R3 all ones signed", 32'hFFFF_FFFF, 32'd1, 1'b1);
        run_mul("R8 min x min", 32'h8000_0000, 32'h8000_0000, 1'b1);
        run_mul("R8 min x one", 32'h8000_0000, 32'd1, 1'b1);
        run_mul("R8 min unsigned", 32'h8000_0000, 32'h8000_0000, 1'b0);
        test_busy_start();
        run_mul("R3 neg x zero", 32'hFFFF_FF00, 32'd0, 1'b1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule